// File: doc/BRIEF.md
# Write Queue with Same-Address Merging and Drain Barrier

This block sits between a processor's store port and the memory port. Stores are not sent to memory when they are issued. They are held in a small ordered queue and released in bursts. A burst starts once the number of queued distinct addresses reaches a programmable threshold, or once a barrier request is waiting. A store whose address is already queued does not take a new slot. It overwrites the data of the queued entry, so memory sees a single write for that address, and that write carries the latest value.

The barrier input forces a complete drain. Its completion pulse fires only when the queue is empty and memory has acknowledged the last write, so all earlier stores are in memory by then. Loads are looked up in the queue and in the write currently in flight, and they get the buffered value one cycle later. The memory side uses a request/acknowledge pair with at most one write outstanding.

Top module: `store_buffer`

## Requirements
- R1: After synchronous reset the queue is empty, `st_ready` is 1, and `mem_req`, `fence_done`, `ld_rvalid` and `ld_hit` are all 0.
- R2: An accepted store is queued and not written to memory while the occupancy is below `THRESH` and no barrier is waiting.
- R3: A store to an address already queued (other than an entry leaving the queue in that same cycle) replaces that entry's data and takes no new slot. Exactly one memory write occurs for the address, and it carries the newest data.
- R4: Queued entries reach memory in the order their addresses were first inserted.
- R5: A drain write is launched only while the occupancy is at least `THRESH` or a barrier is waiting. Without a barrier, draining stops once the occupancy falls below `THRESH`.
- R6: `mem_req` stays high, with `mem_addr` and `mem_data` stable, until `mem_ack` is sampled high. It then drops for at least one cycle, so at most one write is outstanding.
- R7: `fence_done` is a single-cycle pulse. It is raised only after a `fence_req`, once the queue has been empty and no write has been outstanding in the previous cycle.
- R8: A load with `ld_valid` gives `ld_rvalid` one cycle later. `ld_hit`=1 and `ld_data` hold the queued entry for that address if one exists, otherwise the in-flight write's data if its address matches. If neither matches, `ld_hit`=0.
- R9: `st_ready` is 0 only when all `DEPTH` slots are occupied and `st_addr` matches no queued entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | AW | Load address |
| ld_rvalid | output | 1 | Lookup result valid (one cycle after request) |
| ld_hit | output | 1 | Lookup found buffered data |
| ld_data | output | DW | Forwarded data |
| fence_req | input | 1 | Barrier request pulse |
| fence_done | output | 1 | Barrier completion pulse |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | AW | Memory write address |
| mem_data | output | DW | Memory write data |
| mem_ack | input | 1 | Memory write acknowledge |

## Verification
The bench targets repeated stores to one address. A design that appends instead of merging would show extra or stale memory writes, and one that moves the merged entry to the tail would break first-insertion order. It holds off memory acknowledges while the queue is full. This exposes a store port that refuses merging stores, or that accepts new addresses into a full queue, and a barrier pulse that fires while a write is still unacknowledged. Loads of the in-flight address are also checked, since a lookup that only searches the queue would miss data that has left it but is not yet in memory.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic {
    FN_IDLE = 1'b0,
    FN_WAIT = 1'b1
  } fence_state_t;
endpackage

// File: rtl/sb_queue.sv
module sb_queue #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          pop,
  input  logic [AW-1:0] lk_addr,
  output logic [CW-1:0] cnt,
  output logic          wr_match,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          lk_hit,
  output logic [DW-1:0] lk_data
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] q_addr [DEPTH];
  logic [DW-1:0] q_data [DEPTH];
  logic [DEPTH-1:0] wr_vec, lk_vec;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cmp
      assign wr_vec[g] = (CW'(g) < cnt) && (q_addr[g] == wr_addr);
      assign lk_vec[g] = (CW'(g) < cnt) && (q_addr[g] == lk_addr);
    end
  endgenerate

  assign wr_match  = |wr_vec;
  assign head_addr = q_addr[0];
  assign head_data = q_data[0];

  // merge target: an entry leaving this cycle cannot absorb the store
  logic          abs_en;
  logic [IW-1:0] abs_idx, abs_dst, app_dst;
  logic [CW-1:0] app_pos;

  always_comb begin
    abs_en  = 1'b0;
    abs_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_vec[i] && !(pop && i == 0)) begin
        abs_en  = 1'b1;
        abs_idx = IW'(i);
      end
    end
    abs_dst = pop ? abs_idx - IW'(1) : abs_idx;
    app_pos = pop ? cnt - CW'(1) : cnt;
    app_dst = app_pos[IW-1:0];
  end

  always_comb begin
    lk_hit  = 1'b0;
    lk_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lk_vec[i]) begin
        lk_hit  = 1'b1;
        lk_data = q_data[i];
      end
    end
  end

  logic do_append;
  assign do_append = wr_en && !abs_en;

  always_ff @(posedge clk) begin
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        q_addr[i] <= q_addr[i+1];
        q_data[i] <= q_data[i+1];
      end
    end
    if (wr_en && abs_en) begin
      q_data[abs_dst] <= wr_data;
    end
    if (do_append) begin
      q_addr[app_dst] <= wr_addr;
      q_data[app_dst] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      cnt <= cnt - CW'(pop) + CW'(do_append);
    end
  end
endmodule

// File: rtl/sb_drain.sv
module sb_drain #(
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int CW     = 4,
  parameter int THRESH = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic          flush,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  input  logic          mem_ack,
  output logic          pop,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data
);
  logic batch_ok;
  assign batch_ok = (cnt >= CW'(THRESH)) || flush;
  assign pop      = !mem_req && (cnt != '0) && batch_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else if (mem_req) begin
      if (mem_ack) mem_req <= 1'b0;
    end else if (pop) begin
      mem_req  <= 1'b1;
      mem_addr <= head_addr;
      mem_data <= head_data;
    end
  end
endmodule

// File: rtl/sb_fence.sv
module sb_fence
  import sb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fence_req,
  input  logic empty,
  input  logic busy,
  output logic waiting,
  output logic done
);
  fence_state_t st;

  assign waiting = (st == FN_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= FN_IDLE;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (fence_req) begin
        st <= FN_WAIT;
      end else if (st == FN_WAIT && empty && !busy) begin
        st   <= FN_IDLE;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/store_buffer.sv
module store_buffer #(
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int DEPTH  = 8,
  parameter int THRESH = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_rvalid,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  input  logic          fence_req,
  output logic          fence_done,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          mem_ack
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] occ;
  logic          wr_match, pop, fence_wait, lk_hit;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data, lk_data;

  assign st_ready = (occ != CW'(DEPTH)) || wr_match;

  sb_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .CW(CW)) u_queue (
    .clk(clk), .rst(rst),
    .wr_en(st_valid && st_ready), .wr_addr(st_addr), .wr_data(st_data),
    .pop(pop), .lk_addr(ld_addr),
    .cnt(occ), .wr_match(wr_match),
    .head_addr(head_addr), .head_data(head_data),
    .lk_hit(lk_hit), .lk_data(lk_data)
  );

  sb_drain #(.AW(AW), .DW(DW), .CW(CW), .THRESH(THRESH)) u_drain (
    .clk(clk), .rst(rst), .cnt(occ), .flush(fence_wait),
    .head_addr(head_addr), .head_data(head_data), .mem_ack(mem_ack),
    .pop(pop), .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  sb_fence u_fence (
    .clk(clk), .rst(rst), .fence_req(fence_req),
    .empty(occ == '0), .busy(mem_req),
    .waiting(fence_wait), .done(fence_done)
  );

  // queued entry is always newer than the in-flight write
  logic fly_hit;
  assign fly_hit = mem_req && (mem_addr == ld_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_rvalid <= 1'b0;
      ld_hit    <= 1'b0;
      ld_data   <= '0;
    end else begin
      ld_rvalid <= ld_valid;
      ld_hit    <= ld_valid && (lk_hit || fly_hit);
      if (ld_valid) ld_data <= lk_hit ? lk_data : mem_data;
    end
  end
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int DEPTH  = 8,
  parameter int THRESH = 6,
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          st_ready,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_data,
  input logic          fence_done,
  input logic [CW-1:0] occ,
  input logic          fence_wait
);
  a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_data));

  a_r6_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> !mem_req);

  a_r5_launch_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> ($past(occ) >= CW'(THRESH)) || $past(fence_wait));

  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    fence_done |-> $past(occ) == '0 && !$past(mem_req));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    fence_done |=> !fence_done);

  a_r9_ready_full: assert property (@(posedge clk) disable iff (rst)
    !st_ready |-> occ == CW'(DEPTH));
endmodule

bind store_buffer sb_checker #(
  .AW(AW), .DW(DW), .DEPTH(DEPTH), .THRESH(THRESH)
) u_sb_chk (
  .clk(clk), .rst(rst), .st_ready(st_ready),
  .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_data(mem_data),
  .fence_done(fence_done), .occ(occ), .fence_wait(fence_wait)
);

// File: tb/store_buffer_bench.sv
module store_buffer_bench;
  localparam int AW = 8, DW = 16, DEPTH = 8, THRESH = 6;
  localparam int NV = 10;
  // {addr, data}; two batches of five, each with fewer than THRESH distinct addresses
  localparam logic [23:0] VEC [NV] = '{
    {8'h10, 16'h1111}, {8'h20, 16'h2222}, {8'h10, 16'h3333}, {8'h30, 16'h4444}, {8'h20, 16'h5555},
    {8'h40, 16'h0A0A}, {8'h40, 16'h0B0B}, {8'h40, 16'h0C0C}, {8'h50, 16'h0D0D}, {8'h60, 16'h0E0E}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic st_valid = 1'b0, ld_valid = 1'b0, fence_req = 1'b0, mem_ack = 1'b0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic st_ready, ld_rvalid, ld_hit, fence_done, mem_req;
  logic [DW-1:0] ld_data, mem_data;
  logic [AW-1:0] mem_addr;

  int checks = 0, errors = 0, nlog = 0, ndone = 0, cycles = 0;
  logic ack_en = 1'b1;
  logic [AW-1:0] log_a [64];
  logic [DW-1:0] log_d [64];
  logic [AW-1:0] exp_a [16];
  logic [DW-1:0] exp_d [16];
  int nexp;

  always #2 clk = ~clk;

  store_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .THRESH(THRESH)) u_store_buffer (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_rvalid(ld_rvalid), .ld_hit(ld_hit), .ld_data(ld_data),
    .fence_req(fence_req), .fence_done(fence_done),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack)
  );

  // memory model: one-cycle acknowledge, logs each write
  always @(negedge clk) begin
    cycles++;
    if (fence_done) ndone++;
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req && ack_en) begin
      mem_ack = 1'b1;
      if (nlog < 64) begin log_a[nlog] = mem_addr; log_d[nlog] = mem_data; end
      nlog++;
    end
  end

  initial begin
    while (cycles < 20000) @(negedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d cycles expected<20000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic load_chk(input logic [AW-1:0] a, input logic hit, input logic [DW-1:0] d, input string tag);
    @(negedge clk); ld_valid = 1'b1; ld_addr = a;
    @(negedge clk); ld_valid = 1'b0;
    chk(ld_rvalid, {tag, " rvalid"}, int'(ld_rvalid), 1);
    chk(ld_hit == hit, {tag, " hit"}, int'(ld_hit), int'(hit));
    if (hit) chk(ld_data == d, {tag, " data"}, int'(ld_data), int'(d));
  endtask

  task automatic fence_and_wait(input string tag);
    int d0;
    d0 = ndone;
    @(negedge clk); fence_req = 1'b1;
    @(negedge clk); fence_req = 1'b0;
    for (int i = 0; i < 200 && ndone == d0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(ndone == d0 + 1, {tag, " one done pulse"}, ndone - d0, 1);
  endtask

  task automatic cmp_log(input int base, input string tag);
    chk(nlog == base + nexp, {tag, " write count"}, nlog - base, nexp);
    for (int i = 0; i < nexp; i++) begin
      chk(log_a[base+i] == exp_a[i], {tag, " order addr"}, int'(log_a[base+i]), int'(exp_a[i]));
      chk(log_d[base+i] == exp_d[i], {tag, " merged data"}, int'(log_d[base+i]), int'(exp_d[i]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(st_ready == 1'b1, "R1 st_ready", int'(st_ready), 1);
    chk(mem_req == 1'b0, "R1 mem_req", int'(mem_req), 0);
    chk(fence_done == 1'b0 && ld_rvalid == 1'b0 && ld_hit == 1'b0, "R1 outputs idle",
        int'({fence_done, ld_rvalid, ld_hit}), 0);
    rst = 1'b0;

    // table walk: two batches, model merges in first-insertion order
    for (int b = 0; b < 2; b++) begin
      int base;
      base = nlog;
      nexp = 0;
      for (int v = b * 5; v < b * 5 + 5; v++) begin
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic found;
        a = VEC[v][23:16]; d = VEC[v][15:0]; found = 1'b0;
        store(a, d);
        for (int k = 0; k < nexp; k++)
          if (exp_a[k] == a) begin exp_d[k] = d; found = 1'b1; end
        if (!found) begin exp_a[nexp] = a; exp_d[nexp] = d; nexp++; end
        load_chk(a, 1'b1, d, "R8 forward newest");
      end
      repeat (10) @(negedge clk);
      chk(nlog == base, "R2 held below threshold", nlog - base, 0);
      fence_and_wait("R7 batch fence");
      cmp_log(base, "R3 R4 batch");
    end
    load_chk(8'h10, 1'b0, '0, "R8 miss after drain");

    // R5 threshold drain without a barrier
    begin
      int base;
      base = nlog;
      for (int i = 0; i < THRESH; i++) store(8'h70 + 8'(i), 16'h7000 + 16'(i));
      repeat (20) @(negedge clk);
      chk(nlog == base + 1, "R5 drains to below threshold", nlog - base, 1);
      chk(log_a[base] == 8'h70, "R5 oldest first", int'(log_a[base]), 'h70);
      fence_and_wait("R7 threshold fence");
      nexp = THRESH;
      for (int i = 0; i < THRESH; i++) begin exp_a[i] = 8'h70 + 8'(i); exp_d[i] = 16'h7000 + 16'(i); end
      cmp_log(base, "R4 threshold");
    end

    // R9 backpressure and R7/R6 with memory stalled
    begin
      int base, d0;
      base = nlog;
      ack_en = 1'b0;
      for (int i = 0; i < 9; i++) store(8'h80 + 8'(i), 16'h8000 + 16'(i));
      @(negedge clk); st_valid = 1'b1; st_addr = 8'h99; st_data = 16'h9999; #1;
      chk(st_ready == 1'b0, "R9 full new addr refused", int'(st_ready), 0);
      st_addr = 8'h83; #1;
      chk(st_ready == 1'b1, "R9 full merge accepted", int'(st_ready), 1);
      st_valid = 1'b0;
      store(8'h83, 16'hBEEF);
      d0 = ndone;
      @(negedge clk); fence_req = 1'b1;
      @(negedge clk); fence_req = 1'b0;
      repeat (20) @(negedge clk);
      chk(ndone == d0, "R7 no done while write pending", ndone - d0, 0);
      chk(mem_req == 1'b1 && mem_addr == 8'h80, "R6 request held", int'(mem_addr), 'h80);
      load_chk(8'h80, 1'b1, 16'h8000, "R8 in-flight forward");
      ack_en = 1'b1;
      for (int i = 0; i < 200 && ndone == d0; i++) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(ndone == d0 + 1, "R7 done after drain", ndone - d0, 1);
      nexp = 9;
      for (int i = 0; i < 9; i++) begin exp_a[i] = 8'h80 + 8'(i); exp_d[i] = 16'h8000 + 16'(i); end
      exp_d[3] = 16'hBEEF;
      cmp_log(base, "R3 R4 stalled");
    end

    // R7 barrier on an empty buffer still pulses once
    fence_and_wait("R7 empty fence");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule